// File: doc/BRIEF.md
# Mailbox Channel Request Dispatcher

This block sits behind a processor's register write port and turns each 32-bit word written into its send window into a request for one of several child channels. The low four bits of the word pick the channel. The whole word, including those four bits, goes to that channel.

When the chosen child is idle, the word leaves on that child's forward strobe in the same cycle as the write. When the child reports busy, the word is parked at the tail of a local transmit queue. Some later stage, outside this block, empties the queue. A word is discarded, with a one-cycle error pulse, in two cases: its channel number is not implemented, or the queue is already full.

Software reads two values combinationally. One is a status word for the queue. The other is the oldest parked word.

Top module: `mbox_dispatch`

## Requirements
- R1: After reset the queue is empty. The status word at read offset 0xB8 is 0x4000_0000, and neither a forward strobe nor the error pulse is active.
- R2: Only writes to byte offsets 0xA0, 0xA4, 0xA8 and 0xAC are send requests. A write to any other offset forwards nothing, parks nothing and raises no error pulse.
- R3: The target channel is bits [3:0] of the written word. A send whose channel is NCH (default 9) or higher is dropped: no strobe fires, the queue is unchanged and the error pulse fires.
- R4: A send to an implemented, idle channel while the queue is not full raises `fwd_valid[ch]`, and only that bit, for exactly the write cycle. During that cycle `fwd_data` carries the full written word.
- R5: A send to an implemented channel whose `ch_busy` bit is high, while the queue is not full, raises no strobe and appends the word to the queue tail, so the level grows by one.
- R6: A send that arrives while the queue holds DEPTH (default 8) words is dropped with the error pulse. This holds even when its channel is idle: no strobe fires and the queue is unchanged.
- R7: Read offset 0xB8 returns bit 31 = queue full, bit 30 = queue empty and bits [7:0] = number of queued words, with all other bits zero.
- R8: Read offset 0xBC returns the oldest queued word, or zero when the queue is empty. Words are kept in arrival order. Any other read offset returns zero.
- R9: `drop_evt` is high for exactly the cycle of each dropped send and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data / request word |
| rd_addr | input | 8 | Read byte offset (combinational read) |
| rd_data | output | 32 | Read data |
| ch_busy | input | NCH | Per-channel busy indication |
| fwd_valid | output | NCH | Per-channel forward strobe |
| fwd_data | output | 32 | Forwarded word, valid while a strobe is high |
| drop_evt | output | 1 | One-cycle pulse per discarded send |

## Verification
Two behaviours can collide in one cycle: the direct forward to an idle child and the full-queue drop. The bench provokes this by parking words until the queue is full and then sending to a channel whose busy bit is low. Its model expects the error pulse and no strobe.

A second collision is an out-of-range channel number together with random busy bits. Here the drop must win whatever the busy vector holds. Random streams interleave forwards, parks and drops with status and head reads. These are judged each cycle against a queue model kept in the bench.

// File: rtl/mbox_dispatch.sv
module mbox_dispatch #(
  parameter int DW    = 32,
  parameter int NCH   = 9,
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [7:0]     rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [NCH-1:0] ch_busy,
  output logic [NCH-1:0] fwd_valid,
  output logic [DW-1:0]  fwd_data,
  output logic           drop_evt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] count;
  logic [DW-1:0] q [DEPTH];

  logic [3:0]  ch;
  logic [15:0] busy_pad;
  logic        is_send, ch_ok, full, empty, accept, busy_sel, park;

  assign is_send  = wr_en && (wr_addr[7:4] == 4'hA) && (wr_addr[1:0] == 2'b00);
  assign ch       = wr_data[3:0];
  assign ch_ok    = 32'(ch) < NCH;
  assign full     = (32'(count) == DEPTH);
  assign empty    = (count == '0);
  assign busy_pad = 16'(ch_busy);
  assign busy_sel = busy_pad[ch];
  assign accept   = is_send && !full && ch_ok;
  assign park     = accept && busy_sel;
  assign drop_evt = is_send && !accept;

  assign fwd_valid = (accept && !busy_sel) ? (NCH'(1) << ch) : '0;
  assign fwd_data  = wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (park)  count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (park) q[count[IW-1:0]] <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      8'hB8: begin
        rd_data[DW-1]  = full;
        rd_data[DW-2]  = empty;
        rd_data[7:0]   = 8'(count);
      end
      8'hBC: rd_data = empty ? '0 : q[0];
      default: rd_data = '0;
    endcase
  end
endmodule

module mbox_dispatch_chk #(
  parameter int DW    = 32,
  parameter int NCH   = 9,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [7:0]     wr_addr,
  input logic [DW-1:0]  wr_data,
  input logic [NCH-1:0] ch_busy,
  input logic [NCH-1:0] fwd_valid,
  input logic [DW-1:0]  fwd_data,
  input logic           drop_evt,
  input logic [CW-1:0]  cnt
);
  logic win;
  assign win = wr_en && (wr_addr inside {8'hA0, 8'hA4, 8'hA8, 8'hAC});

  AST_FWD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd_valid)); // R4
  AST_FWD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid & ch_busy) == '0); // R5
  AST_FWD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (|fwd_valid) |-> (fwd_data == wr_data && win)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= DEPTH); // R6
  AST_FULL_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) == DEPTH && win) |-> (drop_evt && fwd_valid == '0)); // R6
  AST_PARK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !drop_evt && fwd_valid == '0) |=> (cnt == $past(cnt) + 1'b1)); // R5
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (cnt == $past(cnt))); // R9
  AST_DROP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> win); // R2
  AST_BAD_CH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (win && 32'(wr_data[3:0]) >= NCH) |-> (drop_evt && fwd_valid == '0)); // R3
endmodule

bind mbox_dispatch mbox_dispatch_chk #(.DW(DW), .NCH(NCH), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ch_busy(ch_busy), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
  .drop_evt(drop_evt), .cnt(count)
);

// File: tb/sim_mbox_dispatch.sv
module sim_mbox_dispatch;
  localparam int NCH = 9;
  localparam int DEPTH = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data, fwd_data;
  logic [NCH-1:0] ch_busy = 0, fwd_valid;
  logic drop_evt;

  int errors = 0, checks = 0;
  logic [31:0] mq [DEPTH];
  int mcnt = 0;

  always #5 clk = ~clk;

  mbox_dispatch #(.NCH(NCH), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ch_busy(ch_busy),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .drop_evt(drop_evt));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] r = 0;
    if (a == 8'hB8) begin
      r[31] = (mcnt == DEPTH);
      r[30] = (mcnt == 0);
      r[7:0] = 8'(mcnt);
    end else if (a == 8'hBC) begin
      r = (mcnt == 0) ? 32'h0 : mq[0];
    end
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; ch_busy = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1; rd_addr = 8'hB8;
    mcnt = 0;
    #1;
    chk(rd_data == 32'h4000_0000, "R1 status", rd_data, 32'h4000_0000);
    chk(fwd_valid == 0 && drop_evt == 0, "R1 idle outputs", {drop_evt, 23'(fwd_valid)}, 0);
    chk(rd_data == exp_rd(8'hB8), "R7 status after reset", rd_data, exp_rd(8'hB8));
  endtask

  task automatic step(input bit en, input logic [7:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] bz, input logic [7:0] ra);
    bit snd, okc, full, acc, b, epark, edrop;
    logic [NCH-1:0] efv;
    string tag;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d; ch_busy = bz; rd_addr = ra;
    #1;
    snd   = en && (a == 8'hA0 || a == 8'hA4 || a == 8'hA8 || a == 8'hAC);
    okc   = int'(d[3:0]) < NCH;
    full  = (mcnt == DEPTH);
    acc   = snd && !full && okc;
    b     = okc ? bz[d[3:0]] : 1'b0;
    efv   = (acc && !b) ? (NCH'(1) << d[3:0]) : '0;
    epark = acc && b;
    edrop = snd && !acc;
    if (!snd) tag = "R2";
    else if (full) tag = "R6";
    else if (!okc) tag = "R3";
    else if (b) tag = "R5";
    else tag = "R4";
    chk(fwd_valid == efv, {tag, " fwd_valid"}, 32'(fwd_valid), 32'(efv));
    if (efv != 0) chk(fwd_data == d, "R4 fwd_data", fwd_data, d);
    chk(drop_evt == edrop, {tag, " R9 drop_evt"}, 32'(drop_evt), 32'(edrop));
    chk(rd_data == exp_rd(ra), (ra == 8'hBC) ? "R8 head read" : "R7 status read",
        rd_data, exp_rd(ra));
    @(posedge clk);
    if (epark) begin
      mq[mcnt] = d;
      mcnt++;
    end
    #1;
    wr_en = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    do_reset();
    step(1, 8'hA0, 32'hCAFE_0002, '0, 8'hB8);
    step(1, 8'hAC, 32'h1234_5678, 9'h100, 8'hB8);
    step(1, 8'hA4, 32'hDEAD_0009, '0, 8'hBC);
    step(1, 8'hA1, 32'h0000_0001, '0, 8'hB8);
    step(1, 8'hB0, 32'h0000_0003, 9'h1FF, 8'hB8);
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'hA8, 32'hA000_0000 + 32'(i << 4) + 32'(i % NCH), 9'h1FF, 8'hBC);
    step(0, 8'h00, 0, '0, 8'hB8);
    step(1, 8'hA0, 32'h5555_0001, '0, 8'hB8);
    step(1, 8'hA4, 32'h6666_000F, '0, 8'hBC);
    step(1, 8'hA0, 32'h0, '0, 8'h44);
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [7:0] ra;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0: a = 8'hA0; 1: a = 8'hA4; 2: a = 8'hA8; 3: a = 8'hAC;
        4: a = 8'hA0; 5: a = 8'hAC;
        6: a = 8'hA2; 7: a = 8'hB8; 8: a = 8'h9C; default: a = 8'hB0;
      endcase
      sel = $urandom_range(0, 2);
      ra = (sel == 0) ? 8'hB8 : (sel == 1) ? 8'hBC : 8'(($urandom_range(0, 255)) & 8'hFC);
      step($urandom_range(0, 3) != 0, a, $urandom(), NCH'($urandom()), ra);
      if ((mcnt == DEPTH && $urandom_range(0, 5) == 0) || $urandom_range(0, 199) == 0)
        do_reset();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule